// File: doc/BRIEF.md
# Hit-Tagged Event Memory

This block captures the discriminator outputs of a 64-channel binary front-end while a particle train is passing, and plays them back on a single serial line in the quiet period that follows. Each channel delivers two bits, one per threshold. When a crossing strobe arrives inside the acquisition window and at least one of those 128 bits is set, the whole picture of all channels is written as one record. The record also carries the value of a crossing counter and a fixed header byte.

The memory holds 128 records. When it fills, writing stops and an active-low full output is pulled low. That output only ever drives low, so many chips can share one wired line. The shared line is also read back. A low level on it halts writes on every chip, whether or not its own memory is full. After the window closes, a readout start pulse shifts every stored record out, oldest first. A one-cycle done pulse follows the last bit.

Top module: `hit_event_mem`

## Requirements
- R1: After reset, full_n_o is 1, and sdata_vld_o, sdata_o and ro_done_o are 0.
- R2: A record is stored only on a clock where acq_win_i and bx_strobe_i are both high and at least one bit of disc_i is set. A strobe with all bits clear stores nothing, and hit bits without a strobe store nothing.
- R3: A record is 168 bits: header byte (parameter HEADER, default 8'hA5), then the 32-bit crossing tag, then disc_i[127:0]. Channel c occupies disc_i[2c+1:2c]. Each field is sent MSB first.
- R4: The crossing tag of a record equals the number of strobes seen inside the current window before its own strobe. Strobes without hits also count, so the first strobe of a window has tag 0.
- R5: A readout start sampled while idle and outside the window puts the first bit on sdata_o, with sdata_vld_o high, in the next cycle. Records follow oldest first, one bit per cycle, with no gaps.
- R6: ro_done_o is high for exactly one cycle, in the cycle after the last bit. sdata_vld_o is low in that cycle.
- R7: A readout of an empty memory produces no valid bits and raises ro_done_o in the cycle after the start.
- R8: The 128th stored record drives full_n_o low. Further hits in the same window are not stored.
- R9: While full_line_n_i is low, no record is stored. The crossing counter still advances.
- R10: The rising edge of acq_win_i clears the record count and the full state, so full_n_o returns to 1.
- R11: ro_start_i is ignored while acq_win_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disc_i | input | 128 | Two discriminator bits per channel |
| bx_strobe_i | input | 1 | One-cycle strobe per bunch crossing |
| acq_win_i | input | 1 | Acquisition window, high during the train |
| ro_start_i | input | 1 | Starts serial readout |
| full_line_n_i | input | 1 | Level of the shared active-low full line |
| sdata_o | output | 1 | Serial record data |
| sdata_vld_o | output | 1 | sdata_o carries a valid bit |
| full_n_o | output | 1 | Active-low full, pulls the shared line low |
| ro_done_o | output | 1 | One-cycle end-of-readout pulse |

## Verification
A table of eight crossings mixes the following cases:
- empty strobes
- a lone hit in the lowest channel
- a lone hit in the top channel bit
- an unstrobed hit pattern
- patterns with both thresholds set in every channel

Together these show that zero suppression, strobe qualification, tag counting across empty crossings and bit ordering within a record are each handled separately.

A run of 130 distinct hit patterns separates the last stored record from the dropped ones at the full boundary. A wired line pulled low by a neighbour checks that writes halt while the tag keeps counting. Reopening the window with an immediate readout checks both the release of the full line and the empty-memory termination.

// File: rtl/hit_event_mem.sv
module hit_event_mem #(
  parameter int N_CH   = 64,
  parameter int DEPTH  = 128,
  parameter int TAG_W  = 32,
  parameter logic [7:0] HEADER = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2*N_CH-1:0] disc_i,
  input  logic              bx_strobe_i,
  input  logic              acq_win_i,
  input  logic              ro_start_i,
  input  logic              full_line_n_i,
  output logic              sdata_o,
  output logic              sdata_vld_o,
  output logic              full_n_o,
  output logic              ro_done_o
);
  localparam int DW    = 2 * N_CH;
  localparam int REC_W = 8 + TAG_W + DW;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int BW    = $clog2(REC_W);

  logic [REC_W-1:0] mem [DEPTH];
  logic             acq_q;
  logic [CW-1:0]    cnt;
  logic [TAG_W-1:0] bx;
  logic             busy;
  logic [CW-1:0]    rptr;
  logic [BW-1:0]    bitc;
  logic [REC_W-1:0] shreg;

  wire              open_w  = acq_win_i & ~acq_q;
  wire [CW-1:0]     cnt_eff = open_w ? '0 : cnt;
  wire [TAG_W-1:0]  tag     = open_w ? '0 : bx;
  wire              room    = cnt_eff != CW'(DEPTH);
  wire              wr      = acq_win_i & bx_strobe_i & (|disc_i) & room & full_line_n_i;
  wire              go      = ro_start_i & ~acq_win_i & ~busy;
  wire              last_b  = bitc == BW'(REC_W - 1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      acq_q <= 1'b0;
      cnt   <= '0;
      bx    <= '0;
    end else begin
      acq_q <= acq_win_i;
      cnt   <= cnt_eff + CW'(wr);
      if (acq_win_i && bx_strobe_i) bx <= tag + 1'b1;
      else if (open_w)              bx <= '0;
    end

  always_ff @(posedge clk)
    if (wr) mem[cnt_eff[AW-1:0]] <= {HEADER, tag, disc_i};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy      <= 1'b0;
      rptr      <= '0;
      bitc      <= '0;
      shreg     <= '0;
      ro_done_o <= 1'b0;
    end else begin
      ro_done_o <= 1'b0;
      if (open_w) begin
        busy <= 1'b0;
      end else if (go) begin
        if (cnt == '0) begin
          ro_done_o <= 1'b1;
        end else begin
          busy  <= 1'b1;
          shreg <= mem[0];
          rptr  <= CW'(1);
          bitc  <= '0;
        end
      end else if (busy) begin
        if (last_b) begin
          if (rptr == cnt) begin
            busy      <= 1'b0;
            ro_done_o <= 1'b1;
          end else begin
            shreg <= mem[rptr[AW-1:0]];
            rptr  <= rptr + 1'b1;
            bitc  <= '0;
          end
        end else begin
          shreg <= shreg << 1;
          bitc  <= bitc + 1'b1;
        end
      end
    end

  assign sdata_o     = busy & shreg[REC_W-1];
  assign sdata_vld_o = busy;
  assign full_n_o    = cnt != CW'(DEPTH);
endmodule

// File: rtl/hit_event_mem_chk.sv
module hit_event_mem_chk (
  input logic clk,
  input logic rst_n,
  input logic acq_win_i,
  input logic ro_start_i,
  input logic sdata_vld_o,
  input logic full_n_o,
  input logic ro_done_o
);
  assert_done_not_vld_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ro_done_o && sdata_vld_o));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ro_done_o |=> !ro_done_o);

  assert_vld_after_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdata_vld_o) |-> ($past(ro_start_i) && !$past(acq_win_i)));

  assert_no_readout_in_window_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acq_win_i) |-> !sdata_vld_o);

  assert_full_only_in_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full_n_o) |-> $past(acq_win_i));

  assert_open_releases_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acq_win_i) |=> full_n_o);
endmodule

bind hit_event_mem hit_event_mem_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acq_win_i(acq_win_i), .ro_start_i(ro_start_i),
  .sdata_vld_o(sdata_vld_o), .full_n_o(full_n_o), .ro_done_o(ro_done_o)
);

// File: tb/hit_event_mem_tb.sv
module hit_event_mem_tb;
  localparam int REC_W = 168;
  localparam logic [7:0] HDR = 8'hA5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [127:0] disc = '0;
  logic strobe = 1'b0, acq = 1'b0, start = 1'b0, ext_n = 1'b1;
  logic sdata, vld, full_n, done;
  wire  line_n = ext_n & full_n;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [REC_W-1:0] exp_q[$];
  logic [REC_W-1:0] got_q[$];
  logic [31:0] tagc;
  bit done_seen;

  always #10 clk = ~clk;

  hit_event_mem u_dut (
    .clk(clk), .rst_n(rst_n), .disc_i(disc), .bx_strobe_i(strobe),
    .acq_win_i(acq), .ro_start_i(start), .full_line_n_i(line_n),
    .sdata_o(sdata), .sdata_vld_o(vld), .full_n_o(full_n), .ro_done_o(done)
  );

  localparam logic [128:0] VEC [8] = '{
    {1'b1, 128'h0},
    {1'b1, 128'h1},
    {1'b1, {64{2'b10}}},
    {1'b0, 128'hFFFF},
    {1'b1, 128'h8000_0000_0000_0000_0000_0000_0000_0000},
    {1'b1, 128'h0},
    {1'b1, {64{2'b11}}},
    {1'b1, 128'h0123_4567_89AB_CDEF_DEAD_BEEF_0F0F_1234}
  };

  task automatic chk(input bit ok, input string req, input logic [REC_W-1:0] act, input logic [REC_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic open_win();
    @(negedge clk) acq = 1'b1;
    tagc = 0;
    exp_q.delete();
    @(negedge clk);
  endtask

  task automatic close_win();
    @(negedge clk) acq = 1'b0;
    @(negedge clk);
  endtask

  task automatic crossing(input bit stb, input logic [127:0] d, input bit may_store);
    @(negedge clk);
    strobe = stb;
    disc = d;
    if (stb && (|d) && may_store) exp_q.push_back({HDR, tagc, d});
    if (stb) tagc++;
    @(negedge clk);
    strobe = 1'b0;
    disc = '0;
  endtask

  task automatic readout();
    logic [REC_W-1:0] cur;
    int nb;
    int guard;
    got_q.delete();
    cur = '0;
    nb = 0;
    guard = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (vld && guard < 30000) begin
      cur = {cur[REC_W-2:0], sdata};
      nb++;
      if (nb == REC_W) begin
        got_q.push_back(cur);
        nb = 0;
      end
      guard++;
      @(negedge clk);
    end
    done_seen = done;
    chk(nb == 0, "R5 whole records", REC_W'(nb), '0);
    @(negedge clk);
    chk(!done, "R6 done one cycle", REC_W'(done), '0);
  endtask

  task automatic compare(input string req);
    chk(got_q.size() == exp_q.size(), req, REC_W'(got_q.size()), REC_W'(exp_q.size()));
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk(got_q[i] == exp_q[i], req, got_q[i], exp_q[i]);
    chk(done_seen, "R6 done after last bit", REC_W'(done_seen), REC_W'(1));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(full_n === 1'b1, "R1 full_n", REC_W'(full_n), REC_W'(1));
    chk(vld === 1'b0, "R1 vld", REC_W'(vld), '0);
    chk(sdata === 1'b0, "R1 sdata", REC_W'(sdata), '0);
    chk(done === 1'b0, "R1 done", REC_W'(done), '0);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3 R4 R5: table walk
    open_win();
    foreach (VEC[i]) crossing(VEC[i][128], VEC[i][127:0], 1'b1);
    close_win();
    readout();
    compare("R2 R3 R4 R5 table records");

    // R11: start inside window ignored
    open_win();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    begin
      bit any = 0;
      repeat (5) begin
        if (vld || done) any = 1;
        @(negedge clk);
      end
      chk(!any, "R11 start ignored in window", REC_W'(any), '0);
    end

    // R8: fill to the limit
    for (int i = 0; i < 130; i++) begin
      crossing(1'b1, 128'(i + 1), i < 128);
      if (i == 126) chk(full_n === 1'b1, "R8 not full at 127", REC_W'(full_n), REC_W'(1));
      if (i == 127) chk(full_n === 1'b0, "R8 full at 128", REC_W'(full_n), '0);
    end
    close_win();
    chk(full_n === 1'b0, "R8 full held", REC_W'(full_n), '0);
    readout();
    compare("R8 first 128 kept");

    // R10 then R7
    @(negedge clk) acq = 1'b1;
    @(negedge clk);
    chk(full_n === 1'b1, "R10 full released", REC_W'(full_n), REC_W'(1));
    close_win();
    exp_q.delete();
    readout();
    chk(got_q.size() == 0, "R7 empty readout no data", REC_W'(got_q.size()), '0);
    chk(done_seen, "R7 done after start", REC_W'(done_seen), REC_W'(1));

    // R9: external line halts
    open_win();
    crossing(1'b1, 128'h11, 1'b1);
    crossing(1'b1, 128'h22, 1'b1);
    @(negedge clk) ext_n = 1'b0;
    crossing(1'b1, 128'h33, 1'b0);
    crossing(1'b1, 128'h44, 1'b0);
    @(negedge clk) ext_n = 1'b1;
    crossing(1'b1, 128'h55, 1'b1);
    close_win();
    readout();
    compare("R9 halted by shared line");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule